// File: doc/BRIEF.md
# PAL V-Axis Alternation Corrector with Line Averaging

This block sits after a PAL chroma demodulator. The transmitter flips the sign of the V (R−Y) axis on every second line and leaves U alone. This block keeps a local per-line polarity flag that toggles on every line-start strobe and undoes the flip on the lines that carry an inverted V. The flag is kept in step with the transmitted alternation by an identification bit. That bit comes from the half-line-rate component produced by the 90° swing of the burst phase between lines.

Hue errors cancel when the corrected V of one line is combined with the corrected V of the line before it. Earlier designs did this with a glass chroma delay line. Here an on-chip line store of V samples does the same job. A mode input can turn the averaging off, so that corrected V passes straight through and the viewer's eye does the averaging across lines. U is delayed to match V and is not otherwise changed.

Top module: `pal_vswitch_avg`

## Requirements
- R1: While `rst` is high on a clock edge, `out_valid_o`, `u_o`, `v_o` and `v_inv_o` are all 0 after that edge. The polarity flag, the mismatch count and the line history are also cleared.
- R2: A sample accepted with `smp_valid_i` high shows up on the outputs exactly two clock edges later, with `out_valid_o` high. `u_o` equals the input U unchanged.
- R3: The polarity flag is 0 after reset and flips on every `line_start_i`. `v_inv_o` is the flag value that applied to the sample being shown. When the flag is 1, the corrected V is the negated input V; when it is 0, the corrected V is the input V.
- R4: At a line start, the identification bit (`ident_i`, 1 = this line carries inverted V) is compared with the toggled flag value. If they disagree on LOCK_LINES (default 4) consecutive line starts, the flag takes the value of `ident_i` on the last of those line starts. Any agreeing line start clears the disagreement count. Fewer disagreements than LOCK_LINES leave the normal toggle in place.
- R5: Negating the most negative V code (−512 at 10 bits) gives the most positive code (+511).
- R6: The line store address returns to 0 on every line start and advances once per accepted sample. With averaging on, `v_o` is floor((corrected V + stored corrected V of the same sample index on the previous line) / 2).
- R7: V is not averaged on samples before the first line start after reset, nor on the line that the first line start opens. From the second line start on, averaging applies.
- R8: With `avg_en_i` low when a sample is accepted, `v_o` is that sample's corrected V. The line store is still updated.
- R9: A sample accepted in the same cycle as `line_start_i` is the first sample (index 0) of the new line and uses the new line's polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start_i | input | 1 | One-cycle strobe at the start of each line |
| ident_i | input | 1 | Line identification from burst swing, sampled on line start; 1 = inverted V |
| avg_en_i | input | 1 | 1 = average V with previous line, 0 = simple mode |
| smp_valid_i | input | 1 | U/V sample valid |
| u_i | input | SMP_W | Demodulated U, signed |
| v_i | input | SMP_W | Demodulated V, signed |
| out_valid_o | output | 1 | Output sample valid |
| u_o | output | SMP_W | Delayed U, signed |
| v_o | output | SMP_W | Corrected (and optionally averaged) V, signed |
| v_inv_o | output | 1 | Polarity flag applied to the sample on `v_o` |

## Verification
The bench forces the identification bit to disagree on three lines in a row and then on four lines in a row. A design that locks too early, or never locks, shows the wrong `v_inv_o` and a V of the wrong sign on the following lines. An inverted line whose first sample is −512 catches a negation that wraps to −512 instead of saturating. After a second reset mid-run the bench checks that the first line comes out un-averaged, so a design that keeps its history through reset mixes in stale line data. Lines that begin with a sample in the strobe cycle catch an address or polarity that is one sample late.

// File: rtl/pal_alt_pkg.sv
package pal_alt_pkg;
  typedef enum logic {
    VPOL_KEEP = 1'b0,
    VPOL_FLIP = 1'b1
  } vpol_e;
endpackage

// File: rtl/pal_alt_sync.sv
module pal_alt_sync
  import pal_alt_pkg::*;
#(
  parameter int unsigned LOCK_LINES = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  line_start_i,
  input  logic  ident_i,
  output vpol_e pol_o
);
  localparam int unsigned CNT_W = (LOCK_LINES > 1) ? $clog2(LOCK_LINES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_LINES - 1);

  logic             alt_q, alt_new, tog;
  logic [CNT_W-1:0] cnt_q, cnt_new;

  always_comb begin
    tog     = ~alt_q;
    alt_new = tog;
    cnt_new = '0;
    if (ident_i != tog) begin
      if (cnt_q == CNT_LAST) begin
        alt_new = ident_i;
        cnt_new = '0;
      end else begin
        cnt_new = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alt_q <= 1'b0;
      cnt_q <= '0;
    end else if (line_start_i) begin
      alt_q <= alt_new;
      cnt_q <= cnt_new;
    end
  end

  assign pol_o = vpol_e'(line_start_i ? alt_new : alt_q);

  // R4: disagreement count never reaches the lock threshold
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST);
  // R3: flag only moves on a line start
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !line_start_i |=> $stable(alt_q));
  // R3: an agreeing identification leaves a plain toggle
  a_r3_flip: assert property (@(posedge clk) disable iff (rst)
    line_start_i && (ident_i == !alt_q) |=> alt_q != $past(alt_q));
  // R4: at the threshold the flag follows the identification bit
  a_r4_force: assert property (@(posedge clk) disable iff (rst)
    line_start_i && (ident_i == alt_q) && (cnt_q == CNT_LAST)
    |=> alt_q == $past(ident_i));
endmodule

// File: rtl/pal_line_store.sv
module pal_line_store #(
  parameter int unsigned SMP_W = 10,
  parameter int unsigned DEPTH = 1024
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    line_start_i,
  input  logic                    wr_en_i,
  input  logic signed [SMP_W-1:0] wr_data_i,
  output logic signed [SMP_W-1:0] rd_data_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);

  logic signed [SMP_W-1:0] mem [DEPTH];
  logic signed [SMP_W-1:0] rd_q;
  logic [AW-1:0]           addr_q, addr_eff;

  assign addr_eff = line_start_i ? '0 : addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (wr_en_i) begin
      addr_q <= (addr_eff == ADDR_LAST) ? addr_eff : addr_eff + 1'b1;
    end else if (line_start_i) begin
      addr_q <= '0;
    end
  end

  // read-first single-port RAM: old content out, new content in
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      rd_q          <= mem[addr_eff];
      mem[addr_eff] <= wr_data_i;
    end
  end

  assign rd_data_o = rd_q;

  // R6: address restarts at every line start
  a_r6_addr_clear: assert property (@(posedge clk) disable iff (rst)
    line_start_i && !wr_en_i |=> addr_q == '0);
  // R9: a sample in the strobe cycle takes index 0
  a_r9_addr_first: assert property (@(posedge clk) disable iff (rst)
    line_start_i && wr_en_i |=> addr_q == ((DEPTH > 1) ? AW'(1) : '0));
  // R6: address advances by one per sample inside a line
  a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
    !line_start_i && wr_en_i && (addr_q != ADDR_LAST) |=> addr_q == $past(addr_q) + 1'b1);
endmodule

// File: rtl/pal_v_blend.sv
module pal_v_blend
  import pal_alt_pkg::*;
#(
  parameter int unsigned SMP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_i,
  input  logic signed [SMP_W-1:0] u_i,
  input  logic signed [SMP_W-1:0] v_i,
  input  vpol_e                   pol_i,
  input  logic                    avg_i,
  input  logic signed [SMP_W-1:0] hist_i,
  output logic signed [SMP_W-1:0] vcorr_o,
  output logic                    valid_o,
  output logic signed [SMP_W-1:0] u_o,
  output logic signed [SMP_W-1:0] v_o,
  output logic                    inv_o
);
  localparam logic signed [SMP_W-1:0] V_MIN = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic signed [SMP_W-1:0] V_MAX = {1'b0, {(SMP_W-1){1'b1}}};

  logic signed [SMP_W-1:0] u1, v1, v_mix;
  logic signed [SMP_W:0]   sum;
  logic                    val1, avg1, inv1;

  always_comb begin
    if (pol_i == VPOL_FLIP) vcorr_o = (v_i == V_MIN) ? V_MAX : -v_i;
    else                    vcorr_o = v_i;
  end

  assign sum   = {v1[SMP_W-1], v1} + {hist_i[SMP_W-1], hist_i};
  assign v_mix = avg1 ? sum[SMP_W:1] : v1;

  always_ff @(posedge clk) begin
    if (rst) begin
      val1 <= 1'b0; u1 <= '0; v1 <= '0; avg1 <= 1'b0; inv1 <= 1'b0;
      valid_o <= 1'b0; u_o <= '0; v_o <= '0; inv_o <= 1'b0;
    end else begin
      val1 <= valid_i;
      if (valid_i) begin
        u1   <= u_i;
        v1   <= vcorr_o;
        avg1 <= avg_i;
        inv1 <= (pol_i == VPOL_FLIP);
      end
      valid_o <= val1;
      if (val1) begin
        u_o   <= u1;
        v_o   <= v_mix;
        inv_o <= inv1;
      end
    end
  end

  // R2: valid travels through both stages
  a_r2_stage1: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> val1);
  a_r2_stage2: assert property (@(posedge clk) disable iff (rst)
    val1 |=> valid_o);
  // R5: negation of the minimum code saturates
  a_r5_sat: assert property (@(posedge clk) disable iff (rst)
    valid_i && (pol_i == VPOL_FLIP) && (v_i == V_MIN) |=> v1 == V_MAX);
  // R7/R8: without averaging the corrected sample passes as is
  a_r8_raw: assert property (@(posedge clk) disable iff (rst)
    val1 && !avg1 |=> v_o == $past(v1));
endmodule

// File: rtl/pal_vswitch_avg.sv
module pal_vswitch_avg
  import pal_alt_pkg::*;
#(
  parameter int unsigned SMP_W      = 10,
  parameter int unsigned LINE_DEPTH = 1024,
  parameter int unsigned LOCK_LINES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    line_start_i,
  input  logic                    ident_i,
  input  logic                    avg_en_i,
  input  logic                    smp_valid_i,
  input  logic signed [SMP_W-1:0] u_i,
  input  logic signed [SMP_W-1:0] v_i,
  output logic                    out_valid_o,
  output logic signed [SMP_W-1:0] u_o,
  output logic signed [SMP_W-1:0] v_o,
  output logic                    v_inv_o
);
  vpol_e                   pol;
  logic signed [SMP_W-1:0] vcorr, hist;
  logic                    seen_q, hist_q, hist_eff;

  // history becomes usable once a whole line has been stored
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      hist_q <= 1'b0;
    end else if (line_start_i) begin
      seen_q <= 1'b1;
      if (seen_q) hist_q <= 1'b1;
    end
  end

  assign hist_eff = line_start_i ? seen_q : hist_q;

  pal_alt_sync #(.LOCK_LINES(LOCK_LINES)) u_sync (
    .clk(clk), .rst(rst), .line_start_i(line_start_i),
    .ident_i(ident_i), .pol_o(pol)
  );

  pal_line_store #(.SMP_W(SMP_W), .DEPTH(LINE_DEPTH)) u_store (
    .clk(clk), .rst(rst), .line_start_i(line_start_i),
    .wr_en_i(smp_valid_i), .wr_data_i(vcorr), .rd_data_o(hist)
  );

  pal_v_blend #(.SMP_W(SMP_W)) u_blend (
    .clk(clk), .rst(rst), .valid_i(smp_valid_i), .u_i(u_i), .v_i(v_i),
    .pol_i(pol), .avg_i(avg_en_i & hist_eff), .hist_i(hist),
    .vcorr_o(vcorr), .valid_o(out_valid_o), .u_o(u_o), .v_o(v_o),
    .inv_o(v_inv_o)
  );

  // R7: history never valid before a first line start
  a_r7_hist_order: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> !hist_q);
  // R7: one line start alone does not enable averaging
  a_r7_first_line: assert property (@(posedge clk) disable iff (rst)
    line_start_i && !seen_q |=> !hist_q);
endmodule

// File: tb/tb_pal_vswitch_avg.sv
`timescale 1ns/1ps
module tb_pal_vswitch_avg;
  localparam int W   = 10;
  localparam int LEN = 8;
  localparam int NL  = 16;

  // entry: [12] ident disagrees, [11] averaging on, [10] sample in strobe cycle, [9:0] V base
  localparam logic [12:0] LINES [NL] = '{
    {1'b0, 1'b1, 1'b1, 10'sd100},
    {1'b0, 1'b1, 1'b0, -10'sd60},
    {1'b0, 1'b0, 1'b1, -10'sd512},
    {1'b0, 1'b1, 1'b0, 10'sd200},
    {1'b1, 1'b1, 1'b1, 10'sd33},
    {1'b1, 1'b1, 1'b0, -10'sd90},
    {1'b1, 1'b1, 1'b1, 10'sd150},
    {1'b0, 1'b1, 1'b0, -10'sd7},
    {1'b1, 1'b1, 1'b1, 10'sd250},
    {1'b1, 1'b1, 1'b0, -10'sd300},
    {1'b1, 1'b1, 1'b1, 10'sd64},
    {1'b1, 1'b1, 1'b0, -10'sd128},
    {1'b0, 1'b1, 1'b1, 10'sd300},
    {1'b0, 1'b1, 1'b0, -10'sd200},
    {1'b0, 1'b0, 1'b1, 10'sd0},
    {1'b0, 1'b1, 1'b0, 10'sd17}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic line_start_i = 0, ident_i = 0, avg_en_i = 0, smp_valid_i = 0;
  logic signed [W-1:0] u_i = '0, v_i = '0;
  logic out_valid_o, v_inv_o;
  logic signed [W-1:0] u_o, v_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pal_vswitch_avg dut (
    .clk(clk), .rst(rst), .line_start_i(line_start_i), .ident_i(ident_i),
    .avg_en_i(avg_en_i), .smp_valid_i(smp_valid_i), .u_i(u_i), .v_i(v_i),
    .out_valid_o(out_valid_o), .u_o(u_o), .v_o(v_o), .v_inv_o(v_inv_o)
  );

  // reference state built from the requirements
  bit m_alt, m_seen, m_hist;
  int m_cnt, m_addr;
  logic signed [W-1:0] m_prev [LEN];
  bit ea_vld, eb_vld, ea_inv, eb_inv;
  logic signed [W-1:0] ea_u, eb_u, ea_v, eb_v;
  string ea_tag, eb_tag;

  function automatic logic signed [W-1:0] neg_sat(logic signed [W-1:0] x);
    if (x == -512) return 10'sd511;
    return -x;
  endfunction

  task automatic model_reset();
    m_alt = 0; m_seen = 0; m_hist = 0; m_cnt = 0; m_addr = 0;
    ea_vld = 0; eb_vld = 0;
  endtask

  task automatic cmp();
    tests++;
    if (out_valid_o !== eb_vld) begin
      fails++;
      $display("FAIL %s out_valid actual %0b expected %0b", eb_tag, out_valid_o, eb_vld);
    end else if (eb_vld && (u_o !== eb_u || v_o !== eb_v || v_inv_o !== eb_inv)) begin
      fails++;
      $display("FAIL %s u/v/inv actual %0d/%0d/%0b expected %0d/%0d/%0b",
               eb_tag, u_o, v_o, v_inv_o, eb_u, eb_v, eb_inv);
    end
  endtask

  task automatic step(bit ls, bit vld, bit dis, bit av,
                      logic signed [W-1:0] u, logic signed [W-1:0] v, string tag);
    bit id;
    logic signed [W-1:0] vc;
    int s;
    cmp();
    eb_vld = ea_vld; eb_u = ea_u; eb_v = ea_v; eb_inv = ea_inv; eb_tag = ea_tag;
    id = 0;
    if (ls) begin
      id = dis ? m_alt : !m_alt;
      if (id == !m_alt) begin m_alt = !m_alt; m_cnt = 0; end
      else if (m_cnt == 3) begin m_alt = id; m_cnt = 0; end
      else begin m_alt = !m_alt; m_cnt++; end
      if (m_seen) m_hist = 1;
      m_seen = 1;
      m_addr = 0;
    end
    ea_vld = vld; ea_tag = tag;
    if (vld) begin
      vc = m_alt ? neg_sat(v) : v;
      ea_u = u; ea_inv = m_alt;
      if (av && m_hist) begin
        s = int'(vc) + int'(m_prev[m_addr]);
        ea_v = W'(s >>> 1);
      end else ea_v = vc;
      m_prev[m_addr] = vc;
      m_addr++;
    end
    line_start_i = ls; ident_i = id; smp_valid_i = vld;
    avg_en_i = av; u_i = u; v_i = v;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_line(int idx, string tag);
    logic [12:0] e;
    logic signed [W-1:0] base;
    e = LINES[idx];
    base = $signed(e[9:0]);
    if (!e[10]) step(1, 0, e[12], e[11], '0, '0, tag);
    for (int i = 0; i < LEN; i++)
      step(e[10] && i == 0, 1, e[12], e[11], W'(i * 5 - 20), base + W'(13 * i), tag);
    step(0, 0, 0, 0, '0, '0, tag);
  endtask

  function automatic string tag_of(int idx, bit fresh);
    logic [12:0] e;
    e = LINES[idx];
    if (fresh && idx == 0) return "R7,R2,R3";
    if (idx == 2) return "R5,R8,R3";
    if (e[12]) return "R4,R6";
    if (!e[11]) return "R8,R3";
    if (e[10]) return "R9,R6";
    return "R6,R2";
  endfunction

  task automatic do_reset();
    rst = 1; line_start_i = 0; smp_valid_i = 0; ident_i = 0; avg_en_i = 0;
    u_i = '0; v_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (out_valid_o !== 0 || u_o !== 0 || v_o !== 0 || v_inv_o !== 0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %0b/%0d/%0d/%0b expected 0/0/0/0",
               out_valid_o, u_o, v_o, v_inv_o);
    end
    rst = 0;
    model_reset();
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    for (int k = 0; k < NL; k++) run_line(k, tag_of(k, 1));
    step(0, 0, 0, 0, '0, '0, "R2");
    step(0, 0, 0, 0, '0, '0, "R2");
    // reset mid-stream: history must be discarded
    do_reset();
    for (int k = 0; k < 3; k++) run_line(k, (k == 1) ? "R7,R1,R6" : tag_of(k, 1));
    step(0, 0, 0, 0, '0, '0, "R2");
    step(0, 0, 0, 0, '0, '0, "R2");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule